// File: doc/BRIEF.md
# Synchronous Debug Serial Port, Target Side

This block is the target end of a 17-bit synchronous serial link used by a debug host to talk to a stopped core. The host drives a debug clock and a data-in line, both asynchronous to the block's system clock. The block synchronizes them and finds debug-clock rising edges in the system-clock domain. It shifts one received bit in per edge, most significant bit first. When a frame of 17 bits is complete, the block offers the word to a command handler through a valid/ready handshake.

On the way out, the core keeps a 17-bit response value up to date. While no frame is in progress, the transmit shift register reloads from that value on every cycle, and the data-out pin shows its top bit. The first low level of the debug clock in a frame freezes the shift register. From then on the pin advances by one bit after each rising edge, and it only returns to tracking the response once all 17 bits have gone by. Because edges are found by sampling, the debug clock must run at no more than half the system clock rate.

Top module: `dbg_serial_port`

## Requirements
- R1: A frame is 17 debug-clock rising edges; the word handed over carries the first received bit in bit 16 and the last in bit 0.
- R2: The data-in line is captured only on a detected rising edge of the synchronized debug clock; data-in activity while the debug clock holds a level captures nothing.
- R3: One system-clock cycle after the 17th rising edge is detected, `cmd_valid_o` rises; it and `cmd_word_o` stay unchanged until a cycle with `cmd_ready_i` high, after which `cmd_valid_o` falls.
- R4: Outside a frame, with the debug clock high, `dout_o` equals bit 16 of `rsp_word_i` as sampled on the previous system clock edge.
- R5: From the first low debug-clock level in a frame until the frame ends, changes of `rsp_word_i` do not reach `dout_o`.
- R6: Within a frame, `dout_o` presents the frozen response MSB first, advancing one bit only after each rising edge of the debug clock, so before the k-th rising edge (k = 0..16) it shows response bit 16-k.
- R7: While reset is low, `dout_o`, `cmd_valid_o` and `overrun_o` are 0 and the bit counter is cleared; an idle (high) debug clock at reset release starts no frame.
- R8: When a frame completes while a previous word is still valid and not accepted in that cycle, `overrun_o` goes high and the new word replaces the old one; `overrun_o` returns to 0 on the cycle after the next accepted handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dclk_i | input | 1 | Debug serial clock from the host, asynchronous, idles high |
| din_i | input | 1 | Serial data from the host, asynchronous |
| dout_o | output | 1 | Serial data to the host |
| rsp_word_i | input | 17 | Response value kept current by the core (transmit latch) |
| cmd_word_o | output | 17 | Completed received word |
| cmd_valid_o | output | 1 | Received word is waiting for the handler |
| cmd_ready_i | input | 1 | Handler accepts the word this cycle |
| overrun_o | output | 1 | A word was overwritten before it was accepted |

## Verification
The bench scrambles the response value just after the debug clock goes low, so a design that kept reloading from the latch during a frame would put the wrong bits on the pin. It wiggles data-in during both clock levels, which a design that sampled on levels or at the wrong synchronizer stage would capture as garbage. Frames are sent back to back without acceptance to provoke overrun, and a design that kept the old word or never cleared the flag would miscompare. All-ones, all-zero and single-bit patterns in bit 16 expose an off-by-one bit count or a reversed bit order.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic {
    ST_TRACK = 1'b0,
    ST_FRAME = 1'b1
  } frame_st_e;
endpackage

// File: rtl/dsp_rst_sync.sv
module dsp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n = s2_q;
endmodule

// File: rtl/dsp_sync.sv
module dsp_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dsp_rx_core.sv
module dsp_rx_core
  import dsp_pkg::*;
#(
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk_s,
  input  logic              din_s,
  input  logic              cmd_ready_i,
  output logic              rise_o,
  output logic              frame_o,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_valid_o,
  output logic              overrun_o
);
  localparam int                CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(WORD_W - 1);

  frame_st_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-2:0] sh_q, sh_d;
  logic              dclk_q;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;
  logic              ovr_q, ovr_d;
  logic              rise, done, accept;

  assign rise   = dclk_s & ~dclk_q;
  assign accept = valid_q & cmd_ready_i;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    done    = 1'b0;
    case (st_q)
      ST_TRACK: begin
        if (!dclk_s) st_d = ST_FRAME;
      end
      ST_FRAME: begin
        if (rise) begin
          sh_d = {sh_q[WORD_W-3:0], din_s};
          if (cnt_q == LAST) begin
            cnt_d = '0;
            st_d  = ST_TRACK;
            done  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = ST_TRACK;
    endcase
  end

  always_comb begin
    word_d  = word_q;
    valid_d = valid_q;
    ovr_d   = ovr_q;
    if (accept) begin
      valid_d = 1'b0;
      ovr_d   = 1'b0;
    end
    if (done) begin
      word_d  = {sh_q, din_s};
      valid_d = 1'b1;
      if (valid_q && !cmd_ready_i) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_TRACK;
      cnt_q   <= '0;
      sh_q    <= '0;
      dclk_q  <= 1'b1;
      word_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      dclk_q  <= dclk_s;
      word_q  <= word_d;
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rise_o      = rise;
  assign frame_o     = (st_q == ST_FRAME);
  assign cmd_word_o  = word_q;
  assign cmd_valid_o = valid_q;
  assign overrun_o   = ovr_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R1
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !cmd_ready_i) |=> valid_q); // R3
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !cmd_ready_i && !(frame_o && rise)) |=> $stable(word_q)); // R3
  AST_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise) |=> $stable(sh_q)); // R2
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(valid_q)); // R8
endmodule

// File: rtl/dsp_tx_core.sv
module dsp_tx_core #(
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              frame_i,
  input  logic [WORD_W-1:0] rsp_i,
  output logic              dout_o
);
  logic [WORD_W-1:0] tx_q, tx_d;
  logic              load_en, shift_en;

  assign load_en  = ~frame_i;
  assign shift_en = frame_i & rise_i;

  always_comb begin
    tx_d = tx_q;
    if (load_en)       tx_d = rsp_i;
    else if (shift_en) tx_d = {tx_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  assign dout_o = tx_q[WORD_W-1];

  AST_TX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_i) |=> (tx_q == $past(rsp_i))); // R4
  AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && !rise_i) |=> $stable(tx_q)); // R5
  AST_DOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && !rise_i) |=> $stable(dout_o)); // R6
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk_i,
  input  logic              din_i,
  output logic              dout_o,
  input  logic [WORD_W-1:0] rsp_word_i,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              overrun_o
);
  logic       rst_sn;
  logic [1:0] pins_s;
  logic       rise, frame;

  dsp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (rst_sn)
  );

  dsp_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d_i   ({dclk_i, din_i}),
    .q_o   (pins_s)
  );

  dsp_rx_core #(.WORD_W(WORD_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_sn),
    .dclk_s      (pins_s[1]),
    .din_s       (pins_s[0]),
    .cmd_ready_i (cmd_ready_i),
    .rise_o      (rise),
    .frame_o     (frame),
    .cmd_word_o  (cmd_word_o),
    .cmd_valid_o (cmd_valid_o),
    .overrun_o   (overrun_o)
  );

  dsp_tx_core #(.WORD_W(WORD_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_sn),
    .rise_i  (rise),
    .frame_i (frame),
    .rsp_i   (rsp_word_i),
    .dout_o  (dout_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    (!rst_sn) |-> (!cmd_valid_o && !overrun_o && !dout_o)); // R7
endmodule

// File: tb/dbg_serial_port_tb.sv
module dbg_serial_port_tb;
  localparam int W = 17;

  logic         clk = 1'b0;
  logic         rst_n, dclk, din, ready;
  logic [W-1:0] rsp;
  logic         dout, valid, ovr;
  logic [W-1:0] word;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_pend = 0;
  bit exp_ovr  = 0;

  always #5 clk = ~clk;

  dbg_serial_port #(.WORD_W(W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .dclk_i      (dclk),
    .din_i       (din),
    .dout_o      (dout),
    .rsp_word_i  (rsp),
    .cmd_word_o  (word),
    .cmd_valid_o (valid),
    .cmd_ready_i (ready),
    .overrun_o   (ovr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [W-1:0] cmd, input logic [W-1:0] r, input bit scramble);
    rsp = r;
    cyc(3);
    chk("R4 idle dout tracks rsp msb", 32'(dout), 32'(r[W-1]));
    dclk = 1'b0;
    cyc(6);
    if (scramble) rsp = W'($urandom);
    for (int i = W - 1; i >= 0; i--) begin
      din = ~cmd[i];
      cyc(2);
      din = cmd[i];
      cyc(3);
      if (i == W - 1 && scramble)
        chk("R5 dout frozen after rsp change", 32'(dout), 32'(r[i]));
      else
        chk("R6 dout bit before edge", 32'(dout), 32'(r[i]));
      dclk = 1'b1;
      cyc(3);
      din = ~din;
      cyc(1);
      if (i > 0) dclk = 1'b0;
    end
    cyc(1);
    exp_ovr  = exp_ovr | exp_pend;
    exp_pend = 1'b1;
    chk("R1 received word", 32'(word), 32'(cmd));
    chk("R3 valid after frame", 32'(valid), 32'd1);
    chk("R8 overrun flag", 32'(ovr), 32'(exp_ovr));
  endtask

  task automatic accept();
    ready = 1'b1;
    cyc(1);
    ready = 1'b0;
    cyc(1);
    exp_pend = 1'b0;
    exp_ovr  = 1'b0;
    chk("R3 valid drops after accept", 32'(valid), 32'd0);
    chk("R8 overrun cleared by accept", 32'(ovr), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd4711));
    rst_n = 1'b0; dclk = 1'b1; din = 1'b0; ready = 1'b0; rsp = '0;
    cyc(3);
    chk("R7 reset dout", 32'(dout), 32'd0);
    chk("R7 reset valid", 32'(valid), 32'd0);
    chk("R7 reset overrun", 32'(ovr), 32'd0);
    rst_n = 1'b1;
    cyc(5);
    chk("R7 no frame from idle clock", 32'(valid), 32'd0);

    // R2: data-in toggles with the debug clock held high
    for (int k = 0; k < 12; k++) begin
      din = ~din;
      cyc(1);
    end
    chk("R2 no capture without edge", 32'(valid), 32'd0);

    // R4: tracking while idle
    for (int k = 0; k < 6; k++) begin
      rsp = W'($urandom);
      cyc(1);
      chk("R4 idle tracking", 32'(dout), 32'(rsp[W-1]));
    end

    // directed frames
    send_frame(17'h1A5C3, 17'h0F0F1, 1'b0);
    held = word;
    cyc(5);
    chk("R3 valid held without ready", 32'(valid), 32'd1);
    chk("R3 word held without ready", 32'(word), 32'(held));
    accept();

    send_frame(17'h10000, 17'h1FFFF, 1'b1);
    send_frame(17'h0FFFF, 17'h00000, 1'b1);
    chk("R8 newest word kept", 32'(word), 32'h0FFFF);
    accept();
    send_frame(17'h1FFFF, 17'h10001, 1'b1);
    accept();
    send_frame(17'h00001, 17'h15555, 1'b0);
    accept();

    // random frames
    for (int k = 0; k < 25; k++) begin
      send_frame(W'($urandom), W'($urandom), 1'($urandom));
      if ($urandom % 3 != 0) accept();
    end
    if (exp_pend) accept();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule